// File: doc/BRIEF.md
# Serially programmed two-slot card power switch controller

This block drives the switch enables of a power multiplexer that feeds two removable card slots. Each slot has a core supply output and a programming supply output. Each output can connect to one of three sources, or it can be left floating. A host programs the block over three slow wires: a data line, a shift clock and a load strobe. The host shifts in a 9-bit control word, most significant bit first, and then pulses the strobe. On the strobe the new word takes effect.

All three serial wires are asynchronous to the system clock. Each is resynchronised, and the block acts on the rising edges it detects. The active word is decoded into one target selection per output. A per-output sequencer then moves the switches towards that target. It never lets two switches of one output be closed together, and it holds the output fully open for a fixed dead time between two different closed switches. Three conditions force every switch open, and they are handled as one: a cleared enable bit in the word, an active thermal fault input, and reset. Per-output overcurrent reports are merged into one active-low flag and do not alter any switch.

Top module: `pswctl_top`

## Requirements
- R1: After reset every switch enable of all four outputs is 0 and `oc_n` is 1 while no overcurrent is reported. The active control word is reset to all zeros, which is the shutdown state.
- R2: `ser_dat` is sampled on each rising edge of `ser_clk`. The first of nine bits becomes D8 and the ninth becomes D0. Shifting alone never changes any switch output.
- R3: A rising edge on `ser_lat` copies the nine shifted bits into the active control word. The outputs follow that word.
- R4: When D8 of the active word is 0, all twelve switch enables are 0 whatever the other bits hold.
- R5: Core outputs decode a 2-bit code. Slot A uses {D3,D2} and slot B uses {D6,D7}, with the first-named bit as MSB. Code 00 or 11 closes the ground switch (enable bit 0). Code 01 closes the low-voltage switch (bit 1). Code 10 closes the high-voltage switch (bit 2).
- R6: Programming outputs decode a 2-bit code. Slot A uses {D0,D1} and slot B uses {D4,D5}, with the first-named bit as MSB. Code 00 closes ground (bit 0). Code 01 routes the slot's core supply (bit 1). Code 10 closes the programming supply (bit 2). Code 11 leaves all three open.
- R7: At most one enable bit of any output is 1 in any cycle.
- R8: When an output moves from one closed switch to a different one, it first opens fully. It then stays fully open for exactly DEAD_CYC system clock cycles (default 4) before the new switch closes.
- R9: While `therm_fault` is 1, all switches open within one cycle. After it clears, the outputs return to the decoded selection.
- R10: `oc_n` is 0 exactly while any bit of `oc_in` is 1. Bit 0 is core A, bit 1 is prog A, bit 2 is core B and bit 3 is prog B. Overcurrent reports leave every switch enable unchanged.
- R11: A change that affects only one output leaves the enables of every other output untouched at all times, including during the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_lat | input | 1 | Serial load strobe, asynchronous |
| therm_fault | input | 1 | Over-temperature report, system domain |
| oc_in | input | 4 | Per-output overcurrent reports |
| vcca_sw | output | 3 | Slot A core switches: ground, low, high |
| vppa_sw | output | 3 | Slot A prog switches: ground, core route, prog supply |
| vccb_sw | output | 3 | Slot B core switches |
| vppb_sw | output | 3 | Slot B prog switches |
| oc_n | output | 1 | Merged overcurrent flag, active low |

## Verification
The hardest situation to reach is the exact dead-time window. It needs one output moving between two closed switches while its neighbours stay settled, and its observation depends on counting cycles across the resynchroniser and sequencer latency. The stimulus first programs a word that settles slot A's core output on the high supply. It then shifts and latches a word that changes only that code to the low supply. A monitor measures the length of the all-open gap on that output and watches the other core output for any movement in the same window. A word that is shifted but not latched, and a thermal fault raised over a settled word, cover the cases where nothing, or everything, must change.

// File: rtl/pswctl_pkg.sv
package pswctl_pkg;

  localparam int SW_N   = 3;  // switches per output
  localparam int WORD_W = 9;  // serial control word width
  localparam int OUT_N  = 4;  // core A, prog A, core B, prog B

  localparam int SW_GND = 0;
  localparam int SW_LO  = 1;
  localparam int SW_HI  = 2;

  typedef logic [SW_N-1:0] sw_t;

  // core supply code to one-hot switch selection
  function automatic sw_t core_sel(input logic [1:0] code);
    sw_t s;
    s = '0;
    unique case (code)
      2'b01:   s[SW_LO]  = 1'b1;
      2'b10:   s[SW_HI]  = 1'b1;
      default: s[SW_GND] = 1'b1;
    endcase
    return s;
  endfunction

  // programming supply code to one-hot switch selection (11 floats)
  function automatic sw_t prog_sel(input logic [1:0] code);
    sw_t s;
    s = '0;
    unique case (code)
      2'b00:   s[SW_GND] = 1'b1;
      2'b01:   s[SW_LO]  = 1'b1;
      2'b10:   s[SW_HI]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pswctl_sync.sv
module pswctl_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[i]  = s2_q;
    assign rise[i] = s2_q & ~s3_q;
  end

endmodule

// File: rtl/pswctl_word.sv
module pswctl_word #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load_en,
  output logic [W-1:0] word_q
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      if (shift_en) sh_q <= {sh_q[W-2:0], bit_in};
      if (load_en)  word_q <= sh_q;
    end
  end

  // R3: a load strobe transfers the pending bits
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (word_q == $past(sh_q)));

  // R2: without a load strobe the active word holds
  a_r2_shift_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_q));

endmodule

// File: rtl/pswctl_bbm.sv
module pswctl_bbm #(
  parameter int N        = 3,
  parameter int DEAD_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tgt,
  output logic [N-1:0] sw_q
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);

  logic [CW-1:0] cnt_q;
  logic          mismatch, breaking, waiting;

  assign mismatch = (tgt != sw_q);
  assign breaking = mismatch && (sw_q != '0);
  assign waiting  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      cnt_q <= '0;
    end else if (breaking) begin
      sw_q  <= '0;
      cnt_q <= CW'(DEAD_CYC - 1);
    end else if (waiting) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (mismatch) begin
      sw_q <= tgt;
    end
  end

  // R7: never two switches of one output at once
  a_r7_one_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_q));

  // R8: a closed switch can only stay or open, never hand over directly
  a_r8_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q != '0) |=> ((sw_q == '0) || $stable(sw_q)));

  // R8: the output stays open while the dead time runs
  a_r8_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q == '0 && waiting) |=> (sw_q == '0));

endmodule

// File: rtl/pswctl_top.sv
module pswctl_top
  import pswctl_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_lat,
  input  logic       therm_fault,
  input  logic [3:0] oc_in,
  output logic [2:0] vcca_sw,
  output logic [2:0] vppa_sw,
  output logic [2:0] vccb_sw,
  output logic [2:0] vppb_sw,
  output logic       oc_n
);

  logic [2:0]        s_lvl, s_rise;
  logic [WORD_W-1:0] ctrl;
  logic              force_open;
  sw_t               tgt [OUT_N];
  sw_t               sw  [OUT_N];
  sw_t               dec [OUT_N];

  // bit 0 data, bit 1 shift clock, bit 2 load strobe
  pswctl_sync #(.N(3)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_lat, ser_clk, ser_dat}),
    .lvl      (s_lvl),
    .rise     (s_rise)
  );

  logic unused_sync;
  assign unused_sync = ^{s_lvl[2:1], s_rise[0]};

  pswctl_word #(.W(WORD_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (s_rise[1]),
    .bit_in   (s_lvl[0]),
    .load_en  (s_rise[2]),
    .word_q   (ctrl)
  );

  assign force_open = !ctrl[8] || therm_fault;

  assign dec[0] = core_sel({ctrl[3], ctrl[2]});
  assign dec[1] = prog_sel({ctrl[0], ctrl[1]});
  assign dec[2] = core_sel({ctrl[6], ctrl[7]});
  assign dec[3] = prog_sel({ctrl[4], ctrl[5]});

  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    assign tgt[g] = force_open ? '0 : dec[g];
    pswctl_bbm #(.N(SW_N), .DEAD_CYC(DEAD_CYC)) u_bbm (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt   (tgt[g]),
      .sw_q  (sw[g])
    );
  end

  assign vcca_sw = sw[0];
  assign vppa_sw = sw[1];
  assign vccb_sw = sw[2];
  assign vppb_sw = sw[3];
  assign oc_n    = ~|oc_in;

  // R4: a cleared enable bit opens everything one cycle later
  a_r4_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[8] |=> ({vcca_sw, vppa_sw, vccb_sw, vppb_sw} == '0));

  // R9: thermal fault opens everything one cycle later
  a_r9_thermal: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |=> ({vcca_sw, vppa_sw, vccb_sw, vppb_sw} == '0));

  // R10: settled outputs do not react to overcurrent reports
  a_r10_oc_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ctrl) && !force_open && (dec[0] == sw[0]) && (dec[1] == sw[1])
     && (dec[2] == sw[2]) && (dec[3] == sw[3]))
    |=> $stable({vcca_sw, vppa_sw, vccb_sw, vppb_sw}));

endmodule

// File: tb/tb_pswctl_top.sv
module tb_pswctl_top;

  localparam int DEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic       therm_fault = 1'b0;
  logic [3:0] oc_in = '0;
  logic [2:0] vcca_sw, vppa_sw, vccb_sw, vppb_sw;
  logic       oc_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pswctl_top #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .therm_fault(therm_fault), .oc_in(oc_in),
    .vcca_sw(vcca_sw), .vppa_sw(vppa_sw), .vccb_sw(vccb_sw),
    .vppb_sw(vppb_sw), .oc_n(oc_n)
  );

  // fields: enable, coreA, progA, coreB, progB codes; expected coreA, progA, coreB, progB
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 2'b01, 2'b01, 2'b10, 2'b10, 3'b010, 3'b010, 3'b100, 3'b100},
    {1'b1, 2'b10, 2'b10, 2'b01, 2'b00, 3'b100, 3'b100, 3'b010, 3'b001},
    {1'b1, 2'b11, 2'b11, 2'b00, 2'b11, 3'b001, 3'b000, 3'b001, 3'b000},
    {1'b1, 2'b00, 2'b00, 2'b11, 2'b01, 3'b001, 3'b001, 3'b001, 3'b010},
    {1'b0, 2'b10, 2'b10, 2'b10, 2'b10, 3'b000, 3'b000, 3'b000, 3'b000},
    {1'b1, 2'b10, 2'b01, 2'b01, 2'b10, 3'b100, 3'b010, 3'b010, 3'b100}
  };

  function automatic logic [8:0] mkw(input logic en, input logic [1:0] ca,
      input logic [1:0] pa, input logic [1:0] cb, input logic [1:0] pb);
    logic [8:0] w;
    w[8] = en;
    w[3] = ca[1]; w[2] = ca[0];
    w[6] = cb[1]; w[7] = cb[0];
    w[0] = pa[1]; w[1] = pa[0];
    w[4] = pb[1]; w[5] = pb[0];
    return w;
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [8:0] w);
    for (int i = 8; i >= 0; i--) begin
      ser_dat = w[i];
      cyc(4);
      ser_clk = 1'b1;
      cyc(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    cyc(4);
    ser_lat = 1'b1;
    cyc(4);
    ser_lat = 1'b0;
  endtask

  function automatic logic [12:0] outs();
    return {1'b0, vcca_sw, vppa_sw, vccb_sw, vppb_sw};
  endfunction

  // R7 monitor: one-hot-or-zero on every cycle
  int inv_bad = 0;
  always @(negedge clk)
    if (rst_n && (!$onehot0(vcca_sw) || !$onehot0(vppa_sw) ||
                  !$onehot0(vccb_sw) || !$onehot0(vppb_sw)))
      inv_bad++;

  // R8 / R11 monitor: open gap on core A, movement of core B
  logic       armed = 1'b0;
  int         zrun, gap;
  logic       b_moved;
  logic [2:0] b_ref;
  always @(negedge clk) begin
    if (!armed) begin
      zrun = 0; gap = 0; b_moved = 1'b0; b_ref = vccb_sw;
    end else begin
      if (vcca_sw == 3'b000) zrun++;
      else if (zrun != 0) begin gap = zrun; zrun = 0; end
      if (vccb_sw != b_ref) b_moved = 1'b1;
    end
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    check("R1 reset switches", outs(), 13'd0);
    check("R1 reset flag", {12'd0, oc_n}, 13'd1);

    // table walk: R3 R4 R5 R6
    for (int k = 0; k < 6; k++) begin
      logic [20:0] v;
      v = VEC[k];
      shift_word(mkw(v[20], v[19:18], v[17:16], v[15:14], v[13:12]));
      strobe();
      cyc(40);
      check(v[20] ? "R5 R6 R3 decode" : "R4 shutdown", outs(), {1'b0, v[11:0]});
    end

    // R8 R11: core A high -> low, nothing else changes
    armed = 1'b1;
    cyc(1);
    shift_word(mkw(1'b1, 2'b01, 2'b01, 2'b01, 2'b10));
    strobe();
    cyc(40);
    check("R8 dead gap", 13'(gap), 13'(DEAD));
    check("R8 final core A", {10'd0, vcca_sw}, 13'b010);
    check("R11 core B still", {12'd0, b_moved}, 13'd0);
    armed = 1'b0;

    // R2: shift without strobe leaves outputs alone
    shift_word(mkw(1'b0, 2'b00, 2'b00, 2'b00, 2'b00));
    cyc(40);
    check("R2 no strobe", outs(), {1'b0, 3'b010, 3'b010, 3'b010, 3'b100});
    // R3: strobe alone applies the pending word, here a shutdown
    strobe();
    cyc(20);
    check("R3 R4 strobe applies", outs(), 13'd0);

    // R9 thermal
    shift_word(mkw(1'b1, 2'b10, 2'b10, 2'b10, 2'b10));
    strobe();
    cyc(40);
    check("R9 before fault", outs(), {1'b0, 12'b100100100100});
    therm_fault = 1'b1;
    cyc(2);
    check("R9 fault opens", outs(), 13'd0);
    cyc(10);
    therm_fault = 1'b0;
    cyc(20);
    check("R9 recover", outs(), {1'b0, 12'b100100100100});

    // R10 overcurrent
    oc_in = 4'b0010;
    cyc(1);
    check("R10 flag low", {12'd0, oc_n}, 13'd0);
    cyc(10);
    check("R10 switches kept", outs(), {1'b0, 12'b100100100100});
    oc_in = 4'b1000;
    cyc(1);
    check("R10 flag low bit3", {12'd0, oc_n}, 13'd0);
    oc_in = 4'b0000;
    cyc(1);
    check("R10 flag high", {12'd0, oc_n}, 13'd1);

    check("R7 invariant", 13'(inv_bad), 13'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule